// File: doc/BRIEF.md
# Interrupt Entry Stack Selector

On entry to an interrupt or exception handler, this block decides which stack the processor switches to. It receives the privilege level of the interrupted code, the privilege level of the handler, an optional stack-table index taken from the gate descriptor, and a flag saying whether the task register currently points at a usable task segment. The task segment's stack contents are presented as flat register inputs: a selector/pointer pair for each of privilege levels 0, 1 and 2, and eight alternate stack-table pointers.

A one-cycle request strobe starts a decision. On the following cycle the block presents the stack segment and stack pointer to load and a valid pulse. It also raises a flag that says whether a stack switch happens, or it signals an invalid-task-segment fault with its vector number. The index names a table entry only in 64-bit mode. There a non-zero index takes priority over the per-level pair. A switch that needs the task segment while the task register is unusable faults instead of loading a stack.

Top module: `irq_stack_sel`

## Requirements
- R1: `done_vld` is high for exactly the one cycle that follows a cycle in which `req` was high, and low in every other cycle.
- R2: In legacy mode (`long_mode`=0) with `tgt_pl` < `cur_pl` and `tr_ok`=1, the result is `new_ss` = the level pair selector at `lvl_ss_flat[tgt_pl*16 +: 16]`, `new_sp` = the low 32 bits of `lvl_sp_flat[tgt_pl*64 +: 64]` with zeros above, and `do_switch`=1.
- R3: In 64-bit mode with `tbl_idx`=0, `tgt_pl` < `cur_pl` and `tr_ok`=1, the result is `new_ss`=0, `new_sp` = the full 64-bit level pointer of `tgt_pl`, and `do_switch`=1.
- R4: In 64-bit mode with `tbl_idx`=k and 1 ≤ k ≤ 8 and `tr_ok`=1, the result is `new_sp` = `tbl_sp_flat[(k-1)*64 +: 64]`, `new_ss`=0 and `do_switch`=1, whatever the relation of `tgt_pl` to `cur_pl`.
- R5: When `tgt_pl` ≥ `cur_pl` and no table entry is in use, the result is `new_ss`=`cur_ss`, `new_sp`=`cur_sp`, `do_switch`=0 and `fault`=0, even if `tr_ok`=0.
- R6: In legacy mode `tbl_idx` has no effect on any output.
- R7: When a switch is needed (R2, R3 or R4 conditions) but `tr_ok`=0, the result is `fault`=1, `fault_vec`=10, `do_switch`=0, and `new_ss`/`new_sp` equal `cur_ss`/`cur_sp`.
- R8: In 64-bit mode a `tbl_idx` of 9 to 15 yields the fault of R7, even with `tr_ok`=1.
- R9: `fault_vec` reads 0 for every result without a fault.
- R10: After reset, all outputs are 0.
- R11: Outputs other than `done_vld` hold their values in cycles that follow a cycle without `req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Decision strobe, one cycle |
| long_mode | input | 1 | 1 = 64-bit mode, 0 = legacy mode |
| tr_ok | input | 1 | Task register holds a usable selector |
| cur_pl | input | 2 | Privilege level of interrupted code |
| tgt_pl | input | 2 | Privilege level of the handler |
| tbl_idx | input | 4 | Stack-table index from the gate, 0 = none |
| cur_ss | input | 16 | Current stack segment selector |
| cur_sp | input | 64 | Current stack pointer |
| lvl_ss_flat | input | 48 | Level stack selectors, level l at bits l*16 |
| lvl_sp_flat | input | 192 | Level stack pointers, level l at bits l*64 |
| tbl_sp_flat | input | 512 | Stack-table pointers, slot s at bits s*64 |
| done_vld | output | 1 | Result valid pulse |
| do_switch | output | 1 | A new stack is loaded |
| fault | output | 1 | Invalid task segment fault |
| fault_vec | output | 8 | Fault vector number (10) or 0 |
| new_ss | output | 16 | Stack segment to load |
| new_sp | output | 64 | Stack pointer to load |

## Verification
The assertions assume that `req` is a clean single-cycle strobe and that the decision inputs are steady in the cycle `req` is high, since the checks on the kept stack compare against the previous cycle's `cur_sp`. The bench drives every input on the falling edge and changes the data inputs only together with `req` or while it is low. It does not pulse `req` in back-to-back cycles except in the directed valid-pulse test, where both requests carry the same inputs.

// File: rtl/irq_stack_pkg.sv
package irq_stack_pkg;

  localparam int PL_W = 2;
  localparam int VEC_W = 8;
  localparam logic [VEC_W-1:0] BAD_TASK_SEG_VEC = 8'd10;

  typedef enum logic [1:0] {
    STK_KEEP  = 2'd0,
    STK_LEVEL = 2'd1,
    STK_TABLE = 2'd2,
    STK_FAULT = 2'd3
  } stk_kind_e;

  // A lower number is a more privileged level.
  function automatic logic f_priv_rise(input logic [PL_W-1:0] cur,
                                       input logic [PL_W-1:0] tgt);
    return tgt < cur;
  endfunction

  function automatic stk_kind_e f_pick_kind(input logic rise,
                                            input logic use_tbl,
                                            input logic tbl_oob,
                                            input logic tr_ok);
    logic need;
    need = rise | use_tbl;
    if ((use_tbl && tbl_oob) || (need && !tr_ok)) return STK_FAULT;
    if (use_tbl) return STK_TABLE;
    if (rise) return STK_LEVEL;
    return STK_KEEP;
  endfunction

endpackage

// File: rtl/stk_level_pick.sv
module stk_level_pick #(
  parameter int SEL_W  = 16,
  parameter int SP_W   = 64,
  parameter int LEVELS = 3
) (
  input  logic [LEVELS*SEL_W-1:0]     ss_flat,
  input  logic [LEVELS*SP_W-1:0]      sp_flat,
  input  logic [irq_stack_pkg::PL_W-1:0] lvl,
  output logic [SEL_W-1:0]            ss_o,
  output logic [SP_W-1:0]             sp_o
);
  logic [SEL_W-1:0] ss_arr [LEVELS];
  logic [SP_W-1:0]  sp_arr [LEVELS];

  for (genvar l = 0; l < LEVELS; l++) begin : g_unpack
    assign ss_arr[l] = ss_flat[l*SEL_W +: SEL_W];
    assign sp_arr[l] = sp_flat[l*SP_W +: SP_W];
  end

  always_comb begin
    ss_o = '0;
    sp_o = '0;
    for (int l = 0; l < LEVELS; l++) begin
      if (lvl == irq_stack_pkg::PL_W'(l)) begin
        ss_o = ss_arr[l];
        sp_o = sp_arr[l];
      end
    end
  end
endmodule

// File: rtl/stk_table_pick.sv
module stk_table_pick #(
  parameter int SP_W  = 64,
  parameter int SLOTS = 8,
  parameter int IDX_W = 4
) (
  input  logic [SLOTS*SP_W-1:0] sp_flat,
  input  logic [IDX_W-1:0]      idx,
  output logic [SP_W-1:0]       sp_o,
  output logic                  named_o,
  output logic                  oob_o
);
  logic [SP_W-1:0] slot_arr [SLOTS];

  for (genvar s = 0; s < SLOTS; s++) begin : g_unpack
    assign slot_arr[s] = sp_flat[s*SP_W +: SP_W];
  end

  assign named_o = (idx != '0);
  assign oob_o   = (idx > IDX_W'(SLOTS));

  // Index k (1..SLOTS) maps to slot k-1.
  always_comb begin
    sp_o = '0;
    for (int s = 0; s < SLOTS; s++) begin
      if (idx == IDX_W'(s + 1)) sp_o = slot_arr[s];
    end
  end
endmodule

// File: rtl/stk_decide.sv
module stk_decide (
  input  logic                           long_mode,
  input  logic                           tr_ok,
  input  logic [irq_stack_pkg::PL_W-1:0] cur_pl,
  input  logic [irq_stack_pkg::PL_W-1:0] tgt_pl,
  input  logic                           tbl_named,
  input  logic                           tbl_oob,
  output irq_stack_pkg::stk_kind_e       kind_o,
  output logic                           rise_o,
  output logic                           use_tbl_o
);
  import irq_stack_pkg::*;

  assign rise_o    = f_priv_rise(cur_pl, tgt_pl);
  assign use_tbl_o = long_mode & tbl_named;
  assign kind_o    = f_pick_kind(rise_o, use_tbl_o, tbl_oob, tr_ok);
endmodule

// File: rtl/irq_stack_sel.sv
module irq_stack_sel #(
  parameter int SEL_W  = 16,
  parameter int SP_W   = 64,
  parameter int LEG_W  = 32,
  parameter int LEVELS = 3,
  parameter int SLOTS  = 8,
  localparam int IDX_W = $clog2(SLOTS + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req,
  input  logic                    long_mode,
  input  logic                    tr_ok,
  input  logic [1:0]              cur_pl,
  input  logic [1:0]              tgt_pl,
  input  logic [IDX_W-1:0]        tbl_idx,
  input  logic [SEL_W-1:0]        cur_ss,
  input  logic [SP_W-1:0]         cur_sp,
  input  logic [LEVELS*SEL_W-1:0] lvl_ss_flat,
  input  logic [LEVELS*SP_W-1:0]  lvl_sp_flat,
  input  logic [SLOTS*SP_W-1:0]   tbl_sp_flat,
  output logic                    done_vld,
  output logic                    do_switch,
  output logic                    fault,
  output logic [7:0]              fault_vec,
  output logic [SEL_W-1:0]        new_ss,
  output logic [SP_W-1:0]         new_sp
);
  import irq_stack_pkg::*;

  localparam int EXT_W = SP_W - LEG_W;

  // Named internal events
  logic [SEL_W-1:0] lvl_ss;
  logic [SP_W-1:0]  lvl_sp;
  logic [SP_W-1:0]  tbl_sp;
  logic             tbl_named;
  logic             tbl_oob;
  logic             priv_rise;
  logic             use_tbl;
  stk_kind_e        kind;
  logic [SEL_W-1:0] nxt_ss;
  logic [SP_W-1:0]  nxt_sp;

  stk_level_pick #(.SEL_W(SEL_W), .SP_W(SP_W), .LEVELS(LEVELS)) u_level (
    .ss_flat(lvl_ss_flat),
    .sp_flat(lvl_sp_flat),
    .lvl    (tgt_pl),
    .ss_o   (lvl_ss),
    .sp_o   (lvl_sp)
  );

  stk_table_pick #(.SP_W(SP_W), .SLOTS(SLOTS), .IDX_W(IDX_W)) u_table (
    .sp_flat(tbl_sp_flat),
    .idx    (tbl_idx),
    .sp_o   (tbl_sp),
    .named_o(tbl_named),
    .oob_o  (tbl_oob)
  );

  stk_decide u_decide (
    .long_mode(long_mode),
    .tr_ok    (tr_ok),
    .cur_pl   (cur_pl),
    .tgt_pl   (tgt_pl),
    .tbl_named(tbl_named),
    .tbl_oob  (tbl_oob),
    .kind_o   (kind),
    .rise_o   (priv_rise),
    .use_tbl_o(use_tbl)
  );

  always_comb begin
    nxt_ss = cur_ss;
    nxt_sp = cur_sp;
    unique case (kind)
      STK_TABLE: begin
        nxt_ss = '0;
        nxt_sp = tbl_sp;
      end
      STK_LEVEL: begin
        if (long_mode) begin
          nxt_ss = '0;
          nxt_sp = lvl_sp;
        end else begin
          nxt_ss = lvl_ss;
          nxt_sp = {{EXT_W{1'b0}}, lvl_sp[LEG_W-1:0]};
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_vld  <= 1'b0;
      do_switch <= 1'b0;
      fault     <= 1'b0;
      fault_vec <= '0;
      new_ss    <= '0;
      new_sp    <= '0;
    end else begin
      done_vld <= req;
      if (req) begin
        do_switch <= (kind == STK_TABLE) || (kind == STK_LEVEL);
        fault     <= (kind == STK_FAULT);
        fault_vec <= (kind == STK_FAULT) ? BAD_TASK_SEG_VEC : '0;
        new_ss    <= nxt_ss;
        new_sp    <= nxt_sp;
      end
    end
  end

  // R1: a result follows every request by one cycle
  a_r1_vld_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> done_vld);
  // R1: no result without a request
  a_r1_no_spurious_vld: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !done_vld);
  // R7: a faulting result never loads a stack
  a_r7_fault_no_switch: assert property (@(posedge clk) disable iff (!rst_n)
    done_vld |-> !(fault && do_switch));
  // R7, R9: vector number tracks the fault flag
  a_r9_vec_matches_fault: assert property (@(posedge clk) disable iff (!rst_n)
    done_vld |-> (fault ? (fault_vec == 8'd10) : (fault_vec == 8'd0)));
  // R3, R4: 64-bit mode switches load a null selector
  a_r3_long_null_ss: assert property (@(posedge clk) disable iff (!rst_n)
    (req && long_mode) |=> (!do_switch || new_ss == '0));
  // R5: a kept stack is the interrupted code's own stack
  a_r5_keep_current: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !priv_rise && !use_tbl) |=> (!do_switch && !fault && new_sp == $past(cur_sp)));
  // R4: a named in-range table entry always switches when the task register is usable
  a_r4_table_switches: assert property (@(posedge clk) disable iff (!rst_n)
    (req && use_tbl && !tbl_oob && tr_ok) |=> do_switch);
  // R11: outputs hold while idle
  a_r11_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> ($stable(new_sp) && $stable(new_ss) && $stable(fault) && $stable(do_switch)));

endmodule

// File: tb/irq_stack_sel_bench.sv
module irq_stack_sel_bench;
  localparam int SEL_W = 16;
  localparam int SP_W  = 64;
  localparam int LV    = 3;
  localparam int SL    = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0;
  logic long_mode = 1'b0;
  logic tr_ok = 1'b1;
  logic [1:0] cur_pl = '0;
  logic [1:0] tgt_pl = '0;
  logic [3:0] tbl_idx = '0;
  logic [SEL_W-1:0] cur_ss = 16'h002B;
  logic [SP_W-1:0]  cur_sp = 64'h1234_5678_9ABC_DEF0;
  logic [LV*SEL_W-1:0] lvl_ss_flat;
  logic [LV*SP_W-1:0]  lvl_sp_flat;
  logic [SL*SP_W-1:0]  tbl_sp_flat;
  logic done_vld, do_switch, fault;
  logic [7:0] fault_vec;
  logic [SEL_W-1:0] new_ss;
  logic [SP_W-1:0] new_sp;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  irq_stack_sel u_irq_stack_sel (
    .clk(clk), .rst_n(rst_n), .req(req), .long_mode(long_mode), .tr_ok(tr_ok),
    .cur_pl(cur_pl), .tgt_pl(tgt_pl), .tbl_idx(tbl_idx), .cur_ss(cur_ss),
    .cur_sp(cur_sp), .lvl_ss_flat(lvl_ss_flat), .lvl_sp_flat(lvl_sp_flat),
    .tbl_sp_flat(tbl_sp_flat), .done_vld(done_vld), .do_switch(do_switch),
    .fault(fault), .fault_vec(fault_vec), .new_ss(new_ss), .new_sp(new_sp)
  );

  function automatic logic [SEL_W-1:0] lvl_ss_of(input int l);
    return 16'h0010 + 16'(l * 8);
  endfunction
  function automatic logic [SP_W-1:0] lvl_sp_of(input int l);
    return 64'hFFFF_0000_0000_1000 + 64'(l * 256);
  endfunction
  function automatic logic [SP_W-1:0] slot_sp_of(input int s);
    return 64'hA000_0000_0000_0000 + 64'(s * 65536);
  endfunction

  initial begin
    for (int l = 0; l < LV; l++) begin
      lvl_ss_flat[l*SEL_W +: SEL_W] = lvl_ss_of(l);
      lvl_sp_flat[l*SP_W +: SP_W]   = lvl_sp_of(l);
    end
    for (int s = 0; s < SL; s++) tbl_sp_flat[s*SP_W +: SP_W] = slot_sp_of(s);
  end

  task automatic check(input string tag, input logic [159:0] act, input logic [159:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Vector: [19:16] req no, [15] long, [14] tr_ok, [13:12] cur, [11:10] tgt,
  // [9:6] idx, [5] exp switch, [4] exp fault, [3:0] source
  // (0 = current stack, 1 = level pair of tgt, 2+s = table slot s)
  localparam int NV = 16;
  localparam logic [19:0] VECS [NV] = '{
    {4'd2, 1'b0, 1'b1, 2'd3, 2'd0, 4'd0,  1'b1, 1'b0, 4'd1}, // R2
    {4'd2, 1'b0, 1'b1, 2'd3, 2'd1, 4'd0,  1'b1, 1'b0, 4'd1}, // R2
    {4'd5, 1'b0, 1'b1, 2'd2, 2'd2, 4'd0,  1'b0, 1'b0, 4'd0}, // R5
    {4'd6, 1'b0, 1'b1, 2'd3, 2'd0, 4'd5,  1'b1, 1'b0, 4'd1}, // R6
    {4'd6, 1'b0, 1'b1, 2'd1, 2'd1, 4'd3,  1'b0, 1'b0, 4'd0}, // R6
    {4'd7, 1'b0, 1'b0, 2'd3, 2'd0, 4'd0,  1'b0, 1'b1, 4'd0}, // R7
    {4'd5, 1'b0, 1'b0, 2'd0, 2'd0, 4'd0,  1'b0, 1'b0, 4'd0}, // R5
    {4'd3, 1'b1, 1'b1, 2'd3, 2'd0, 4'd0,  1'b1, 1'b0, 4'd1}, // R3
    {4'd3, 1'b1, 1'b1, 2'd3, 2'd2, 4'd0,  1'b1, 1'b0, 4'd1}, // R3
    {4'd4, 1'b1, 1'b1, 2'd3, 2'd0, 4'd1,  1'b1, 1'b0, 4'd2}, // R4
    {4'd4, 1'b1, 1'b1, 2'd0, 2'd0, 4'd8,  1'b1, 1'b0, 4'd9}, // R4
    {4'd4, 1'b1, 1'b1, 2'd2, 2'd0, 4'd4,  1'b1, 1'b0, 4'd5}, // R4
    {4'd7, 1'b1, 1'b0, 2'd0, 2'd0, 4'd2,  1'b0, 1'b1, 4'd0}, // R7
    {4'd8, 1'b1, 1'b1, 2'd3, 2'd0, 4'd9,  1'b0, 1'b1, 4'd0}, // R8
    {4'd8, 1'b1, 1'b1, 2'd0, 2'd0, 4'd15, 1'b0, 1'b1, 4'd0}, // R8
    {4'd5, 1'b1, 1'b1, 2'd0, 2'd3, 4'd0,  1'b0, 1'b0, 4'd0}  // R5
  };

  task automatic run_req(input logic lm, input logic ok, input logic [1:0] c,
                         input logic [1:0] t, input logic [3:0] ix);
    @(negedge clk);
    long_mode = lm; tr_ok = ok; cur_pl = c; tgt_pl = t; tbl_idx = ix; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [SEL_W-1:0] e_ss;
    logic [SP_W-1:0]  e_sp;
    logic [SP_W-1:0]  hold_sp;
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 reset", {86'd0, done_vld, do_switch, fault, fault_vec, new_ss, new_sp},
          160'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: nothing valid without a request
    check("R1 idle vld", {159'd0, done_vld}, 160'd0);

    for (int i = 0; i < NV; i++) begin
      logic [19:0] v;
      logic [3:0] src;
      int tl;
      v = VECS[i];
      src = v[3:0];
      tl = int'(v[11:10]);
      run_req(v[15], v[14], v[13:12], v[11:10], v[9:6]);
      if (src == 4'd1) begin
        e_ss = v[15] ? 16'h0 : lvl_ss_of(tl);
        e_sp = v[15] ? lvl_sp_of(tl) : {32'h0, lvl_sp_of(tl)[31:0]};
      end else if (src >= 4'd2) begin
        e_ss = 16'h0;
        e_sp = slot_sp_of(int'(src) - 2);
      end else begin
        e_ss = cur_ss;
        e_sp = cur_sp;
      end
      // R9 is covered by the vector field comparing fault_vec to 0 without fault
      check($sformatf("R%0d vec%0d", v[19:16], i),
            {69'd0, done_vld, do_switch, fault, fault_vec, new_ss, new_sp},
            {69'd0, 1'b1, v[5], v[4], (v[4] ? 8'd10 : 8'd0), e_ss, e_sp});
    end

    // R1: pulse lasts one cycle
    @(negedge clk);
    check("R1 pulse ends", {159'd0, done_vld}, 160'd0);

    // R1: back-to-back requests keep valid high each cycle
    @(negedge clk);
    long_mode = 1'b0; tr_ok = 1'b1; cur_pl = 2'd3; tgt_pl = 2'd0; tbl_idx = 4'd0;
    req = 1'b1;
    @(negedge clk);
    check("R1 b2b first", {159'd0, done_vld}, 160'd1);
    @(negedge clk);
    req = 1'b0;
    check("R1 b2b second", {159'd0, done_vld}, 160'd1);
    @(negedge clk);
    check("R1 b2b end", {159'd0, done_vld}, 160'd0);

    // R11: outputs hold while inputs change without a request
    hold_sp = new_sp;
    long_mode = 1'b1; tbl_idx = 4'd3; cur_sp = 64'h0BAD_0BAD_0BAD_0BAD; tr_ok = 1'b0;
    repeat (3) @(negedge clk);
    check("R11 hold", {96'd0, new_sp}, {96'd0, hold_sp});
    check("R11 hold flags", {157'd0, do_switch, fault, done_vld}, {157'd0, 3'b100});

    // R6: legacy mode with out-of-range index still no fault
    run_req(1'b0, 1'b1, 2'd3, 2'd2, 4'd12);
    check("R6 legacy oob idx", {150'd0, fault, do_switch, fault_vec},
          {150'd0, 1'b0, 1'b1, 8'd0});

    // R10: re-assert reset clears outputs
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R10 re-reset", {86'd0, done_vld, do_switch, fault, fault_vec, new_ss, new_sp},
          160'd0);
    rst_n = 1'b1;

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule